// File: doc/BRIEF.md
# Interrupt request and mask unit

This unit keeps the six interrupt request latches and the 8-bit interrupt mask of a small 8-bit microcontroller core. Six synchronous, active-high request lines set their latches. The CPU reads and writes the request and mask registers through write strobes, a shared write-data bus and a read-select line. Two single-cycle pulses from the instruction decoder stand for the enable-interrupts and disable-interrupts instructions. The unit drives a per-source pending vector and a single interrupt line to the CPU.

After reset the request latches are locked and hold zero. Only an enable-interrupts pulse unlocks them. Setting the global enable bit through a mask write does not unlock them. Once unlocked they stay unlocked until the next reset. Polling software therefore needs one enable-interrupts pulse as well. A build parameter decides whether mask bit 6, the RAM-protect enable, is implemented or reads as a reserved 0.

Top module: `irq_mask_unit`

## Requirements
- R1: After reset the request register reads 00h, the mask register reads 00h, the pending vector is 0 and the interrupt line is low.
- R2: When the latches are unlocked, a high level on request input i in a cycle sets request bit i at the next clock edge. The bit stays set until software writes it to 0.
- R3: While locked, the request register stays 00h whatever arrives on the request inputs or through software writes to the request register. A request in the same cycle as the unlocking pulse is not latched.
- R4: An enable-interrupts pulse unlocks the latches and sets mask bit 7 at the next edge. A mask write that sets bit 7 leaves the latches locked.
- R5: A disable-interrupts pulse clears mask bit 7 at the next edge and leaves the latches unlocked. If both pulses arrive in the same cycle, bit 7 ends up 0.
- R6: A mask write loads all eight bits from the write data at the next edge. Mask bits 0 to 5 enable sources 0 to 5, bit 6 is RAM-protect enable and bit 7 is global enable. An enable or disable pulse in the same cycle overrides bit 7.
- R7: When the RAM-protect option is absent, mask bit 6 always reads 0.
- R8: When unlocked, a request-register write loads bits 5:0 from the write data. Where the same bit receives a hardware request in that cycle, the bit ends up 1.
- R9: Pending bit i is 1 exactly when request bit i and mask bit i are both 1.
- R10: The interrupt line is high exactly when the latches are unlocked, mask bit 7 is 1 and at least one pending bit is 1.
- R11: With read-select 0 the read data shows the request register in bits 5:0 and 0 in bits 7:6. With read-select 1 it shows the mask register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in | input | 6 | Interrupt request inputs, active high |
| ei_pulse | input | 1 | Enable-interrupts instruction pulse |
| di_pulse | input | 1 | Disable-interrupts instruction pulse |
| req_wr | input | 1 | Write strobe for the request register |
| mask_wr | input | 1 | Write strobe for the mask register |
| wr_data | input | 8 | Write data for both registers |
| rd_sel | input | 1 | Read select: 0 request, 1 mask |
| rd_data | output | 8 | Read data of the selected register |
| pending | output | 6 | Requests that are set and enabled by the mask |
| cpu_irq | output | 1 | Interrupt signal to the CPU |

## Verification
The hardest state to reach is the locked phase while the mask already holds global enable. Two stimulus steps build it: first a mask write of FFh before any enable-interrupts pulse, then requests and software writes to the request register, all of which must leave it at 00h. The stimulus table also lines up same-cycle collisions: a request together with the unlocking pulse, a hardware set against a software clear, a mask write against an enable pulse, and both instruction pulses together. A second instance built without RAM protect sees the same stimulus, so the reserved bit is checked on every step.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned GIE_BIT = 7;
  localparam int unsigned RP_BIT  = 6;

  // Next mask value: software write first, then enable pulse, then disable pulse.
  function automatic logic [REG_W-1:0] mask_next(
    input logic [REG_W-1:0] cur,
    input logic             wr,
    input logic [REG_W-1:0] wd,
    input logic             ei,
    input logic             di,
    input logic             rp_en
  );
    logic [REG_W-1:0] v;
    v = wr ? wd : cur;
    if (!rp_en) v[RP_BIT] = 1'b0;
    if (ei) v[GIE_BIT] = 1'b1;
    if (di) v[GIE_BIT] = 1'b0;
    return v;
  endfunction

  // Next value of one request latch bit.
  function automatic logic req_bit_next(
    input logic armed,
    input logic cur,
    input logic sw_wr,
    input logic sw_bit,
    input logic hw_set
  );
    logic v;
    if (!armed) v = 1'b0;
    else        v = (sw_wr ? sw_bit : cur) | hw_set;
    return v;
  endfunction
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int unsigned N_SRC = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ei_pulse,
  input  logic [N_SRC-1:0] req_in,
  input  logic             sw_wr,
  input  logic [N_SRC-1:0] sw_data,
  output logic             armed,
  output logic [N_SRC-1:0] req_q
);
  import irq_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed <= 1'b0;
    else if (ei_pulse) armed <= 1'b1;
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q[i] <= 1'b0;
      else        req_q[i] <= req_bit_next(armed, req_q[i], sw_wr, sw_data[i], req_in[i]);
    end

    AST_REQ_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && req_in[i]) |=> req_q[i]); // R2

    AST_HW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && sw_wr && !sw_data[i] && req_in[i]) |=> req_q[i]); // R8
  end

  AST_LOCKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> (req_q == '0)); // R3

  AST_STAY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed); // R5
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter bit RP_EN = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr,
  input  logic [irq_pkg::REG_W-1:0] wd,
  input  logic                      ei_pulse,
  input  logic                      di_pulse,
  output logic [irq_pkg::REG_W-1:0] mask_q
);
  import irq_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_next(mask_q, wr, wd, ei_pulse, di_pulse, RP_EN);
  end

  AST_EI_SETS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    (ei_pulse && !di_pulse) |=> mask_q[GIE_BIT]); // R4

  AST_DI_CLEARS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    di_pulse |=> !mask_q[GIE_BIT]); // R5

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (mask_q[5:0] == $past(wd[5:0]))); // R6

  if (!RP_EN) begin : g_no_rp
    AST_RP_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> !mask_q[RP_BIT]); // R7
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int unsigned N_SRC = 6
) (
  input  logic [N_SRC-1:0] req_q,
  input  logic [N_SRC-1:0] src_en,
  input  logic             gie,
  input  logic             armed,
  output logic [N_SRC-1:0] pending,
  output logic             irq
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_pend
    assign pending[i] = req_q[i] & src_en[i];
  end
  assign irq = armed & gie & (|pending);
endmodule

// File: rtl/irq_mask_unit.sv
module irq_mask_unit #(
  parameter bit RP_EN = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] req_in,
  input  logic       ei_pulse,
  input  logic       di_pulse,
  input  logic       req_wr,
  input  logic       mask_wr,
  input  logic [7:0] wr_data,
  input  logic       rd_sel,
  output logic [7:0] rd_data,
  output logic [5:0] pending,
  output logic       cpu_irq
);
  import irq_pkg::*;
  localparam int unsigned N_SRC = 6;
  localparam int unsigned PAD_W = REG_W - N_SRC;

  logic             armed;
  logic [N_SRC-1:0] req_q;
  logic [REG_W-1:0] mask_q;

  irq_req_latch #(.N_SRC(N_SRC)) u_req (
    .clk(clk), .rst_n(rst_n), .ei_pulse(ei_pulse), .req_in(req_in),
    .sw_wr(req_wr), .sw_data(wr_data[N_SRC-1:0]), .armed(armed), .req_q(req_q)
  );

  irq_mask_reg #(.RP_EN(RP_EN)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr(mask_wr), .wd(wr_data),
    .ei_pulse(ei_pulse), .di_pulse(di_pulse), .mask_q(mask_q)
  );

  irq_gate #(.N_SRC(N_SRC)) u_gate (
    .req_q(req_q), .src_en(mask_q[N_SRC-1:0]), .gie(mask_q[GIE_BIT]),
    .armed(armed), .pending(pending), .irq(cpu_irq)
  );

  assign rd_data = rd_sel ? mask_q : {{PAD_W{1'b0}}, req_q};

  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (mask_q[GIE_BIT] && armed)); // R10

  AST_PEND_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (pending & ~req_q) == '0); // R9

  AST_MASKWR_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !ei_pulse) |=> !armed); // R4
endmodule

// File: tb/irq_mask_unit_tb.sv
module irq_mask_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] req_in = '0;
  logic       ei_pulse = 1'b0, di_pulse = 1'b0, req_wr = 1'b0, mask_wr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_sel = 1'b0;
  logic [7:0] rd_data, rd_data_np;
  logic [5:0] pending, pending_np;
  logic       cpu_irq, cpu_irq_np;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_mask_unit #(.RP_EN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .ei_pulse(ei_pulse), .di_pulse(di_pulse),
    .req_wr(req_wr), .mask_wr(mask_wr), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .pending(pending), .cpu_irq(cpu_irq)
  );

  irq_mask_unit #(.RP_EN(1'b0)) u_dut_np (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .ei_pulse(ei_pulse), .di_pulse(di_pulse),
    .req_wr(req_wr), .mask_wr(mask_wr), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data_np), .pending(pending_np), .cpu_irq(cpu_irq_np)
  );

  typedef struct packed {
    logic [5:0] rq;
    logic       ei;
    logic       di;
    logic       rwr;
    logic       mwr;
    logic [7:0] wd;
    logic [5:0] e_req;
    logic [7:0] e_mask;
    logic [5:0] e_pend;
    logic       e_irq;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{6'h3F, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 6'h00, 8'h00, 6'h00, 1'b0}, // R3 locked, requests ignored
    '{6'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 6'h00, 8'hFF, 6'h00, 1'b0}, // R4 R6 mask write no unlock
    '{6'h01, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 6'h00, 8'hFF, 6'h00, 1'b0}, // R4 still locked
    '{6'h00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h3F, 6'h00, 8'hFF, 6'h00, 1'b0}, // R3 sw write ignored
    '{6'h02, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 6'h00, 8'hFF, 6'h00, 1'b0}, // R3 R4 request with EI dropped
    '{6'h04, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 6'h04, 8'hFF, 6'h04, 1'b1}, // R2 R10
    '{6'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 6'h04, 8'h7F, 6'h04, 1'b0}, // R5
    '{6'h08, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 6'h0C, 8'h7F, 6'h0C, 1'b0}, // R5 polling still latches
    '{6'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h81, 6'h0C, 8'h81, 6'h00, 1'b0}, // R6 R9
    '{6'h01, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 6'h0D, 8'h81, 6'h01, 1'b1}, // R2 R9 R10
    '{6'h08, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 6'h08, 8'h81, 6'h00, 1'b0}, // R8 hw set wins
    '{6'h00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h30, 6'h30, 8'h81, 6'h00, 1'b0}, // R8 sw load
    '{6'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA0, 6'h30, 8'hA0, 6'h20, 1'b1}, // R6 R9 R10
    '{6'h00, 1'b1, 1'b0, 1'b0, 1'b1, 8'h20, 6'h30, 8'hA0, 6'h20, 1'b1}, // R6 EI overrides bit 7
    '{6'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 6'h30, 8'h20, 6'h20, 1'b0}  // R5 both pulses
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_inputs();
    req_in = '0; ei_pulse = 1'b0; di_pulse = 1'b0;
    req_wr = 1'b0; mask_wr = 1'b0; wr_data = '0;
  endtask

  // Check both registers, pending and interrupt line of the main instance.
  task automatic check_state(input string req, input logic [5:0] e_req, input logic [7:0] e_mask,
                             input logic [5:0] e_pend, input logic e_irq);
    rd_sel = 1'b0; #1;
    check({req, " req"}, rd_data, {2'b00, e_req});
    rd_sel = 1'b1; #1;
    check({req, " mask"}, rd_data, e_mask);
    check({req, " R7 mask no-protect"}, rd_data_np, e_mask & 8'hBF);
    check({req, " R9 pending"}, pending, e_pend);
    check({req, " R10 irq"}, cpu_irq, e_irq);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    clear_inputs();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    apply_reset();
    // R1 reset state
    check_state("R1", 6'h00, 8'h00, 6'h00, 1'b0);

    // Table walk
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      req_in = VECS[k].rq; ei_pulse = VECS[k].ei; di_pulse = VECS[k].di;
      req_wr = VECS[k].rwr; mask_wr = VECS[k].mwr; wr_data = VECS[k].wd;
      @(posedge clk); #1;
      clear_inputs();
      check_state($sformatf("step%0d", k), VECS[k].e_req, VECS[k].e_mask,
                  VECS[k].e_pend, VECS[k].e_irq);
    end

    // R11: request read pads upper bits with zero even when written with FFh
    @(negedge clk);
    req_wr = 1'b1; wr_data = 8'hFF;
    @(posedge clk); #1;
    clear_inputs();
    rd_sel = 1'b0; #1;
    check("R11 req read upper bits", rd_data, 8'h3F);
    rd_sel = 1'b1; #1;
    check("R11 mask read", rd_data, 8'h20);

    // R1 R3: reset in mid-run relocks the latches
    apply_reset();
    check_state("R1 rereset", 6'h00, 8'h00, 6'h00, 1'b0);
    @(negedge clk);
    req_in = 6'h3F;
    @(posedge clk); #1;
    clear_inputs();
    rd_sel = 1'b0; #1;
    check("R3 locked after rereset", rd_data, 8'h00);

    // R2 R10: unlock, enable source 5, request it; bit holds after input falls
    @(negedge clk);
    ei_pulse = 1'b1;
    mask_wr = 1'b1; wr_data = 8'h20;
    @(posedge clk); #1;
    clear_inputs();
    @(negedge clk);
    req_in = 6'h20;
    @(posedge clk); #1;
    clear_inputs();
    @(negedge clk);
    check_state("R2 hold", 6'h20, 8'hA0, 6'h20, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule